// File: doc/BRIEF.md
# Wake and Sleep Supervisor

This block decides whether a single-wire slave device is awake or asleep. A line decoder in front of it turns activity on the wire into one-cycle strobes: a wake event, the leading edge of any data token, the final bit of a command block, and a transmit token. The supervisor also watches a parse-complete strobe, which carries a command-valid bit, and an execute-complete strobe from the command engine. It produces an awake flag and a one-cycle sleep request for the power logic.

Two timers run while the device is awake. The idle timer returns the device to sleep when the line stays quiet for too long. It stops counting while a command is being handled, and it starts again on the first transmit token once enough time has passed. A malformed command only has to wait out the parse time. A good command must also wait out the execute time. The second timer is a watchdog. It starts at every wake and cannot be cleared, so it forces sleep a fixed number of cycles later, whatever the device is doing.

All intervals are parameters counted in clock cycles: `IDLE_CYC`, `PARSE_CYC`, `EXEC_CYC` and `WDOG_CYC`. In the requirements, "edge E" is the clock edge that samples a strobe, and "edge E+N" is N clock edges later.

Top module: `pwr_wake_supervisor`

## Requirements
- R1: After reset the device is asleep, with `awake` = 0 and `sleepReq` = 0.
- R2: A `wakeStb` sampled at edge E while asleep sets `awake` after edge E. The idle timer and the watchdog both start from zero at that edge.
- R3: While listening, each `tokenEdge` restarts the idle timer, and so does the wake itself. If no `tokenEdge` arrives, `sleepReq` rises after edge E+IDLE_CYC, where E is the last restart. A `tokenEdge` sampled at edge E+IDLE_CYC still counts as a restart and prevents sleep.
- R4: A `cmdEnd` sampled while listening suspends the idle timer. From then until the timer is re-enabled, the idle timer cannot cause sleep, and `tokenEdge` strobes have no effect.
- R5: For a command that `parseDone` reports with `cmdValid` = 0, the idle timer restarts at the first `txToken` sampled after at least PARSE_CYC+1 edges have passed since the `cmdEnd` edge, provided `parseDone` was seen earlier. Earlier `txToken` strobes are ignored.
- R6: For a command that `parseDone` reports with `cmdValid` = 1, a `txToken` re-enables the idle timer only if `execDone` was seen earlier and it is sampled at least PARSE_CYC+EXEC_CYC+1 edges after the `cmdEnd` edge. After a `cmdEnd` at edge C, a `txToken` at edge C+PARSE_CYC+EXEC_CYC is ignored and one at edge C+PARSE_CYC+EXEC_CYC+1 is accepted.
- R7: `sleepReq` rises after edge W+WDOG_CYC, where W is the wake edge. This holds no matter how tokens arrive and also while a command is suspended.
- R8: A `wakeStb` sampled while already awake restarts neither the watchdog nor the idle timer.
- R9: `sleepReq` is high for exactly one cycle. In that cycle `awake` is still 1, and on the next cycle `awake` is 0 and `sleepReq` is 0.
- R10: During the `sleepReq` cycle and while asleep, every strobe other than `wakeStb` is ignored. A later wake starts both timers from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wakeStb | input | 1 | Wake event from the line decoder |
| tokenEdge | input | 1 | Leading edge of a received data token |
| cmdEnd | input | 1 | Final bit of a command block received |
| txToken | input | 1 | Transmit token seen on the line |
| parseDone | input | 1 | Command parsing finished |
| cmdValid | input | 1 | Qualifies `parseDone`: 1 means the command is well formed |
| execDone | input | 1 | Command execution finished |
| awake | output | 1 | Device is awake |
| sleepReq | output | 1 | One-cycle request to enter sleep |

## Verification
The assertions assume that every strobe is a synchronous pulse and that `cmdValid` is only read in the cycle where `parseDone` is high. They do not assume any order between strobes, so strobes that arrive while asleep or while a command is suspended are legal input, and the checks cover them. The stimulus changes inputs only on the falling clock edge and holds each strobe for exactly one rising edge. It drives `parseDone` and `execDone` only while a command is suspended, which matches how a command engine behaves.

// File: rtl/pss_pkg.sv
package pss_pkg;

  typedef enum logic [1:0] {
    ST_ASLEEP = 2'd0,
    ST_LISTEN = 2'd1,
    ST_HOLD   = 2'd2,
    ST_DROP   = 2'd3
  } pwrState_t;

  typedef struct packed {
    logic idleClr;
    logic idleRun;
    logic gateClr;
    logic gateRun;
    logic wdogClr;
    logic wdogRun;
  } tmrCtl_t;

endpackage

// File: rtl/pss_cycle_ctr.sv
module pss_cycle_ctr #(
  parameter int LIMIT = 16,
  parameter int W     = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         run,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] TOP = W'(LIMIT - 1);

  // saturating up-counter; clear wins over run
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (clr)         cnt <= '0;
    else if (run && cnt != TOP) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/pss_timers.sv
module pss_timers
  import pss_pkg::*;
#(
  parameter int IDLE_CYC  = 1000,
  parameter int PARSE_CYC = 50,
  parameter int EXEC_CYC  = 200,
  parameter int WDOG_CYC  = 100000
) (
  input  logic    clk,
  input  logic    rstN,
  input  tmrCtl_t ctl,
  input  logic    parseDone,
  input  logic    cmdValid,
  input  logic    execDone,
  output logic    idleExpire,
  output logic    wdogExpire,
  output logic    gateOpen
);

  localparam int GATE_LIM = PARSE_CYC + EXEC_CYC + 1;
  localparam int IW = (IDLE_CYC > 1) ? $clog2(IDLE_CYC) : 1;
  localparam int WW = (WDOG_CYC > 1) ? $clog2(WDOG_CYC) : 1;
  localparam int GW = (GATE_LIM > 1) ? $clog2(GATE_LIM) : 1;

  logic [IW-1:0] idleCnt;
  logic [WW-1:0] wdogCnt;
  logic [GW-1:0] gateCnt;
  logic          parseSeen, validLat, execSeen;
  logic          parseMet, fullMet;

  pss_cycle_ctr #(.LIMIT(IDLE_CYC), .W(IW)) u_idle (
    .clk(clk), .rstN(rstN), .clr(ctl.idleClr), .run(ctl.idleRun), .cnt(idleCnt));

  pss_cycle_ctr #(.LIMIT(WDOG_CYC), .W(WW)) u_wdog (
    .clk(clk), .rstN(rstN), .clr(ctl.wdogClr), .run(ctl.wdogRun), .cnt(wdogCnt));

  pss_cycle_ctr #(.LIMIT(GATE_LIM), .W(GW)) u_gate (
    .clk(clk), .rstN(rstN), .clr(ctl.gateClr), .run(ctl.gateRun), .cnt(gateCnt));

  // completion flags of the command in flight
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parseSeen <= 1'b0;
      validLat  <= 1'b0;
      execSeen  <= 1'b0;
    end else if (ctl.gateClr) begin
      parseSeen <= 1'b0;
      validLat  <= 1'b0;
      execSeen  <= 1'b0;
    end else if (ctl.gateRun) begin
      if (parseDone) begin
        parseSeen <= 1'b1;
        validLat  <= cmdValid;
      end
      if (execDone) execSeen <= 1'b1;
    end
  end

  always_comb begin
    idleExpire = ctl.idleRun && !ctl.idleClr && (idleCnt == IW'(IDLE_CYC - 1));
    wdogExpire = ctl.wdogRun && (wdogCnt == WW'(WDOG_CYC - 1));
    parseMet   = (gateCnt >= GW'(PARSE_CYC));
    fullMet    = (gateCnt >= GW'(PARSE_CYC + EXEC_CYC));
    gateOpen   = parseSeen && (validLat ? (fullMet && execSeen) : parseMet);
  end

  // a freshly cleared gate never reports ready on the next cycle
  assert_gate_closed_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.gateClr |=> !gateOpen);

endmodule

// File: rtl/pss_ctrl.sv
module pss_ctrl
  import pss_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    wakeStb,
  input  logic    tokenEdge,
  input  logic    cmdEnd,
  input  logic    txToken,
  input  logic    idleExpire,
  input  logic    wdogExpire,
  input  logic    gateOpen,
  output tmrCtl_t ctl,
  output logic    awake,
  output logic    sleepReq
);

  pwrState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_ASLEEP;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    ctl      = '0;
    unique case (state)
      ST_ASLEEP: begin
        ctl.idleClr = 1'b1;
        ctl.gateClr = 1'b1;
        ctl.wdogClr = 1'b1;
        if (wakeStb) stateNxt = ST_LISTEN;
      end
      ST_LISTEN: begin
        ctl.wdogRun = 1'b1;
        ctl.idleRun = 1'b1;
        ctl.idleClr = tokenEdge;
        ctl.gateClr = 1'b1;
        if (idleExpire || wdogExpire) stateNxt = ST_DROP;
        else if (cmdEnd)              stateNxt = ST_HOLD;
      end
      ST_HOLD: begin
        ctl.wdogRun = 1'b1;
        ctl.idleClr = 1'b1;
        ctl.gateRun = 1'b1;
        if (wdogExpire)              stateNxt = ST_DROP;
        else if (txToken && gateOpen) stateNxt = ST_LISTEN;
      end
      ST_DROP: begin
        ctl.idleClr = 1'b1;
        ctl.gateClr = 1'b1;
        ctl.wdogClr = 1'b1;
        stateNxt    = ST_ASLEEP;
      end
      default: stateNxt = ST_ASLEEP;
    endcase
  end

  assign awake    = (state != ST_ASLEEP);
  assign sleepReq = (state == ST_DROP);

  assert_sleep_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    sleepReq |=> (!sleepReq && !awake));

  assert_wake_up_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!awake && wakeStb) |=> awake);

  assert_asleep_ignore_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!awake && !wakeStb) |=> (!awake && !sleepReq));

  assert_hold_no_idle_sleep_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && !wdogExpire) |=> !sleepReq);

endmodule

// File: rtl/pwr_wake_supervisor.sv
module pwr_wake_supervisor
  import pss_pkg::*;
#(
  parameter int IDLE_CYC  = 1000,
  parameter int PARSE_CYC = 50,
  parameter int EXEC_CYC  = 200,
  parameter int WDOG_CYC  = 100000
) (
  input  logic clk,
  input  logic rstN,
  input  logic wakeStb,
  input  logic tokenEdge,
  input  logic cmdEnd,
  input  logic txToken,
  input  logic parseDone,
  input  logic cmdValid,
  input  logic execDone,
  output logic awake,
  output logic sleepReq
);

  tmrCtl_t ctl;
  logic    idleExpire, wdogExpire, gateOpen;

  pss_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .wakeStb(wakeStb), .tokenEdge(tokenEdge), .cmdEnd(cmdEnd), .txToken(txToken),
    .idleExpire(idleExpire), .wdogExpire(wdogExpire), .gateOpen(gateOpen),
    .ctl(ctl), .awake(awake), .sleepReq(sleepReq));

  pss_timers #(
    .IDLE_CYC(IDLE_CYC), .PARSE_CYC(PARSE_CYC),
    .EXEC_CYC(EXEC_CYC), .WDOG_CYC(WDOG_CYC)
  ) u_timers (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .parseDone(parseDone), .cmdValid(cmdValid), .execDone(execDone),
    .idleExpire(idleExpire), .wdogExpire(wdogExpire), .gateOpen(gateOpen));

endmodule

// File: tb/sim_pwr_wake_supervisor.sv
`timescale 1ns/1ps
module sim_pwr_wake_supervisor;

  localparam int IDLE  = 20;
  localparam int PARSE = 6;
  localparam int EXEC  = 10;
  localparam int WDOG  = 300;

  localparam int S_WAKE = 0, S_TOK = 1, S_END = 2, S_TX = 3, S_PARSE = 4, S_EXEC = 5;

  // rows: token count, token spacing, expected cycles from wake edge to sleepReq
  localparam int VEC [5][3] = '{
    '{3, 5, 35}, '{2, 20, 60}, '{1, 21, 20}, '{0, 1, 20}, '{4, 1, 24}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wakeStb = 0, tokenEdge = 0, cmdEnd = 0, txToken = 0;
  logic parseDone = 0, cmdValid = 0, execDone = 0;
  logic awake, sleepReq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  pwr_wake_supervisor #(.IDLE_CYC(IDLE), .PARSE_CYC(PARSE), .EXEC_CYC(EXEC), .WDOG_CYC(WDOG)) u0 (
    .clk(clk), .rstN(rstN), .wakeStb(wakeStb), .tokenEdge(tokenEdge), .cmdEnd(cmdEnd),
    .txToken(txToken), .parseDone(parseDone), .cmdValid(cmdValid), .execDone(execDone),
    .awake(awake), .sleepReq(sleepReq));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clearAll();
    wakeStb = 0; tokenEdge = 0; cmdEnd = 0; txToken = 0; parseDone = 0; execDone = 0;
  endtask

  task automatic pulse(input int id);
    case (id)
      S_WAKE:  wakeStb   = 1;
      S_TOK:   tokenEdge = 1;
      S_END:   cmdEnd    = 1;
      S_TX:    txToken   = 1;
      S_PARSE: parseDone = 1;
      default: execDone  = 1;
    endcase
    @(negedge clk);
    clearAll();
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // cycles after the last pulse until sleepReq, -1 if none within limit
  task automatic waitSleep(input int limit, output int n);
    n = -1;
    for (int k = 1; k <= limit; k++) begin
      @(negedge clk);
      if (sleepReq) begin
        n = k;
        break;
      end
    end
  endtask

  // wake, then tokens every 10 cycles, optional extra wake at cycle 50
  task automatic wdogRun(input bit midWake, output int n);
    n = -1;
    pulse(S_WAKE);
    for (int c = 1; c <= 400; c++) begin
      tokenEdge = (c % 10 == 0);
      wakeStb   = midWake && (c == 50);
      @(negedge clk);
      clearAll();
      if (sleepReq) begin
        n = c;
        break;
      end
    end
    idle(2);
  endtask

  initial begin
    int n;
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 awake after reset", int'(awake), 0);
    chk("R1 sleepReq after reset", int'(sleepReq), 0);

    // R3 / R2: table of token spacing patterns
    for (int r = 0; r < 5; r++) begin
      n = -1;
      pulse(S_WAKE);
      for (int c = 1; c <= 200; c++) begin
        tokenEdge = (c % VEC[r][1] == 0) && (c / VEC[r][1] >= 1) && (c / VEC[r][1] <= VEC[r][0]);
        @(negedge clk);
        clearAll();
        if (sleepReq) begin
          n = c;
          break;
        end
      end
      chk($sformatf("R3 idle timeout row %0d", r), n, VEC[r][2]);
      idle(2);
    end

    // R9: pulse shape
    pulse(S_WAKE);
    waitSleep(100, n);
    chk("R9 awake during sleepReq", int'(awake), 1);
    @(negedge clk);
    chk("R9 sleepReq one cycle", int'(sleepReq), 0);
    chk("R9 awake drops", int'(awake), 0);

    // R10: strobes ignored while asleep, fresh timers after wake
    pulse(S_TOK); pulse(S_END); pulse(S_TX); pulse(S_PARSE); pulse(S_EXEC);
    idle(2);
    chk("R10 stays asleep", int'(awake), 0);
    chk("R10 no sleepReq while asleep", int'(sleepReq), 0);
    pulse(S_WAKE);
    waitSleep(100, n);
    chk("R10 fresh idle timer after wake", n, IDLE);
    idle(2);

    // R4 / R5: malformed command
    pulse(S_WAKE);
    pulse(S_END);
    cmdValid = 0;
    pulse(S_PARSE);
    pulse(S_TOK);
    pulse(S_TX);
    waitSleep(40, n);
    chk("R4 idle suspended after command end", n, -1);
    chk("R5 early txToken ignored", int'(awake), 1);
    pulse(S_TX);
    waitSleep(100, n);
    chk("R5 idle re-enabled by txToken after parse", n, IDLE);
    idle(2);

    // R6: good command, early txToken ignored
    pulse(S_WAKE);
    pulse(S_END);
    cmdValid = 1;
    pulse(S_PARSE);
    pulse(S_EXEC);
    idle(5);
    pulse(S_TX);
    waitSleep(40, n);
    chk("R6 txToken before exec time ignored", n, -1);
    pulse(S_TX);
    waitSleep(100, n);
    chk("R6 idle re-enabled after parse+exec", n, IDLE);
    idle(2);

    // R6 boundary: tx at edge C+16 ignored, at C+17 accepted
    pulse(S_WAKE);
    pulse(S_END);
    pulse(S_PARSE);
    pulse(S_EXEC);
    idle(PARSE + EXEC - 3);
    pulse(S_TX);
    pulse(S_TX);
    waitSleep(100, n);
    chk("R6 boundary txToken acceptance", n, IDLE);
    cmdValid = 0;
    idle(2);

    // R7 / R8: watchdog with steady tokens and a second wake
    wdogRun(1'b1, n);
    chk("R7 R8 watchdog not restarted by wake while awake", n, WDOG);

    // R7: watchdog fires while command suspended
    pulse(S_WAKE);
    pulse(S_END);
    waitSleep(400, n);
    chk("R7 watchdog during suspended command", n, WDOG - 1);
    idle(2);

    // R10: watchdog restarts from zero after re-wake
    wdogRun(1'b0, n);
    chk("R10 watchdog fresh after re-wake", n, WDOG);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule